// File: doc/BRIEF.md
# Single-Step Phase Shift Sequencer

This block sits between a slow control processor and the dynamic phase-adjust port of a clock synthesizer. The processor raises a start request and picks a direction. The sequencer then issues exactly one unit phase step to the synthesizer port and waits for the port to acknowledge the step. After that it parks, and it accepts nothing more until the processor has dropped its request. A slow master can therefore leave its request high for thousands of fast-clock cycles and still get one step, and not a run of them.

The request crosses into the fast clock domain through a synchronizer chain. The direction is captured at the moment the request is accepted. The strobe to the synthesizer stays high until the port has acknowledged and a minimum hold time has elapsed. A watchdog counter ends a step that is never acknowledged and raises an error flag. A signed counter keeps the net number of completed steps.

Top module: `phase_step_seq`

## Requirements
- R1: One high period of `req_start` yields exactly one rising edge of `pll_step`, however long the request stays high.
- R2: With `req_start` rising before clock edge 1, `pll_step` and `busy` go high after the third rising clock edge (SYNC_STAGES=2 synchronizer flops plus the state register).
- R3: `pll_updn` is 1 for a forward (positive) step and 0 for a backward step. It takes the value of `req_dir` at acceptance and stays stable for the whole strobe, even if `req_dir` changes.
- R4: `pll_step` stays high until `pll_done` has been seen and the strobe has lasted at least MIN_HOLD cycles. An acknowledge that arrives earlier is remembered. With an acknowledge that appears L cycles into the strobe, the strobe lasts max(L+1, MIN_HOLD) cycles.
- R5: After a step ends, `step_done` is 1 and `busy` is 0 for as long as the synchronized request stays high. `step_done` clears after the third rising edge following the fall of `req_start`. A `pll_done` pulse that arrives while parked changes nothing.
- R6: If no `pll_done` has been seen within TIMEOUT strobe cycles, the strobe ends after exactly TIMEOUT cycles, `step_err` goes to 1 and `net_steps` does not change. An acknowledge seen in the last allowed cycle counts as success. `step_err` clears when the next request is accepted.
- R7: `net_steps` is a two's-complement CNT_W-bit count. It adds 1 for each completed forward step and subtracts 1 for each completed backward step, wrapping modulo 2^CNT_W (for example, 3 + 1 gives -4 at CNT_W=3).
- R8: Right after reset, `busy`, `step_done`, `step_err` and `pll_step` are 0 and `net_steps` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock of the synthesizer port |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Step request from the slow processor domain |
| req_dir | input | 1 | Requested direction, 1 forward, 0 backward |
| busy | output | 1 | A step is in progress (strobe interval) |
| step_done | output | 1 | The step has finished and the sequencer waits for the request to drop |
| step_err | output | 1 | The last step ended by timeout |
| pll_step | output | 1 | Phase-step strobe to the synthesizer port |
| pll_updn | output | 1 | Direction to the synthesizer port, 1 forward |
| pll_done | input | 1 | Completion acknowledge from the synthesizer port |
| net_steps | output | CNT_W | Signed net count of completed steps |

## Verification
A state register that fails to park, or a lost request interlock, shows up during the hold period as a second rise of `pll_step`, a few cycles after the first step ends. A cycle counter or acknowledge latch that is wrong changes the strobe width, and this can be measured on the very step where it happens. Table entries place the acknowledge at the edges of the hold and timeout windows. A wrong direction latch or accumulator makes `pll_updn` move mid-strobe or makes `net_steps` differ from the running expectation as soon as the step completes. A run of forward steps carries the count through its wrap.

// File: rtl/phase_step_pkg.sv
package phase_step_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_STEP = 2'd1,
      ST_PARK = 2'd2
   } seq_state_t;
endpackage

// File: rtl/phase_step_sync.sv
module phase_step_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   initial begin : p_param_chk
      assert (STAGES >= 2) else $error("STAGES must be at least 2");
   end

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/phase_step_fsm.sv
module phase_step_fsm
   import phase_step_pkg::*;
#(
   parameter int MIN_HOLD = 4,
   parameter int TIMEOUT  = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_s,
   input  logic dir_in,
   input  logic ack_in,
   output logic strobe,
   output logic dir_q,
   output logic parked,
   output logic err_q,
   output logic commit
);
   localparam int CYC_W = $clog2(TIMEOUT + 1);
   localparam logic [CYC_W-1:0] HOLD_LAST = CYC_W'(MIN_HOLD - 1);
   localparam logic [CYC_W-1:0] TMO_LAST  = CYC_W'(TIMEOUT - 1);

   seq_state_t       state;
   logic [CYC_W-1:0] cyc;
   logic             ack_seen;
   logic             ack_now;
   logic             hold_met;

   initial begin : p_param_chk
      assert (MIN_HOLD >= 1) else $error("MIN_HOLD must be at least 1");
      assert (TIMEOUT >= MIN_HOLD) else $error("TIMEOUT must not be below MIN_HOLD");
   end

   assign ack_now  = ack_seen | ack_in;
   assign hold_met = (cyc >= HOLD_LAST);
   assign commit   = (state == ST_STEP) && ack_now && hold_met;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cyc      <= '0;
         ack_seen <= 1'b0;
         dir_q    <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start_s) begin
                  state    <= ST_STEP;
                  cyc      <= '0;
                  ack_seen <= 1'b0;
                  dir_q    <= dir_in;
                  err_q    <= 1'b0;
               end
            end
            ST_STEP: begin
               cyc      <= cyc + 1'b1;
               ack_seen <= ack_now;
               if (commit) begin
                  state <= ST_PARK;
               end else if (cyc == TMO_LAST) begin
                  state <= ST_PARK;
                  err_q <= 1'b1;
               end
            end
            ST_PARK: begin
               if (!start_s) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign strobe = (state == ST_STEP);
   assign parked = (state == ST_PARK);
endmodule

// File: rtl/phase_step_acc.sv
module phase_step_acc #(
   parameter int CNT_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    commit,
   input  logic                    fwd,
   output logic signed [CNT_W-1:0] net
);
   localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      net <= '0;
      else if (commit) net <= fwd ? (net + ONE) : (net - ONE);
   end
endmodule

// File: rtl/phase_step_seq.sv
module phase_step_seq #(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_HOLD    = 4,
   parameter int TIMEOUT     = 64,
   parameter int CNT_W       = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_start,
   input  logic                    req_dir,
   output logic                    busy,
   output logic                    step_done,
   output logic                    step_err,
   output logic                    pll_step,
   output logic                    pll_updn,
   input  logic                    pll_done,
   output logic signed [CNT_W-1:0] net_steps
);
   logic start_s;
   logic strobe;
   logic dir_q;
   logic commit;

   phase_step_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(req_start), .q(start_s)
   );

   phase_step_fsm #(.MIN_HOLD(MIN_HOLD), .TIMEOUT(TIMEOUT)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start_s(start_s), .dir_in(req_dir),
      .ack_in(pll_done), .strobe(strobe), .dir_q(dir_q),
      .parked(step_done), .err_q(step_err), .commit(commit)
   );

   phase_step_acc #(.CNT_W(CNT_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .commit(commit), .fwd(dir_q), .net(net_steps)
   );

   assign pll_step = strobe;
   assign busy     = strobe;
   assign pll_updn = dir_q;
endmodule

// File: rtl/phase_step_chk.sv
module phase_step_chk #(
   parameter int MIN_HOLD = 4,
   parameter int TIMEOUT  = 64,
   parameter int CNT_W    = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    busy,
   input logic                    step_done,
   input logic                    step_err,
   input logic                    pll_step,
   input logic                    pll_updn,
   input logic signed [CNT_W-1:0] net_steps
);
   localparam int RUN_W = $clog2(TIMEOUT + 2);
   logic [RUN_W-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_cnt <= '0;
      else if (pll_step) run_cnt <= run_cnt + 1'b1;
      else               run_cnt <= '0;
   end

   a_r1_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_step) |-> !$past(step_done));

   a_r3_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_step && $past(pll_step)) |-> $stable(pll_updn));

   a_r4_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_step) |-> (run_cnt >= RUN_W'(MIN_HOLD)));

   a_r6_strobe_bound: assert property (@(posedge clk) disable iff (!rst_n)
      pll_step |-> (run_cnt < RUN_W'(TIMEOUT)));

   a_r5_parked_idle: assert property (@(posedge clk) disable iff (!rst_n)
      step_done |-> (!pll_step && !busy));

   a_r7_count_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(net_steps) |-> ($fell(pll_step) && !step_err));

   a_r6_err_no_count: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(step_err) |-> $stable(net_steps));
endmodule

bind phase_step_seq phase_step_chk #(
   .MIN_HOLD(MIN_HOLD), .TIMEOUT(TIMEOUT), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .step_done(step_done),
   .step_err(step_err), .pll_step(pll_step), .pll_updn(pll_updn),
   .net_steps(net_steps)
);

// File: tb/phase_step_seq_bench.sv
module phase_step_seq_bench;
   localparam int MIN_HOLD = 4;
   localparam int TIMEOUT  = 20;
   localparam int CNT_W    = 3;
   localparam int NVEC     = 8;

   // {dir, ack latency (0 = never), expected strobe width, expected error}
   localparam logic [11:0] VEC [NVEC] = '{
      {1'b1, 5'd1,  5'd4,  1'b0},
      {1'b0, 5'd3,  5'd4,  1'b0},
      {1'b1, 5'd5,  5'd6,  1'b0},
      {1'b0, 5'd19, 5'd20, 1'b0},
      {1'b1, 5'd20, 5'd20, 1'b1},
      {1'b1, 5'd0,  5'd20, 1'b1},
      {1'b0, 5'd2,  5'd4,  1'b0},
      {1'b1, 5'd8,  5'd9,  1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_start = 1'b0;
   logic req_dir = 1'b0;
   logic busy, step_done, step_err, pll_step, pll_updn;
   logic pll_done = 1'b0;
   logic signed [CNT_W-1:0] net_steps;

   int errors = 0;
   int checks = 0;
   int model_lat = 0;
   int model_cnt = 0;
   logic signed [CNT_W-1:0] exp_net = '0;

   always #4 clk = ~clk;

   phase_step_seq #(.SYNC_STAGES(2), .MIN_HOLD(MIN_HOLD), .TIMEOUT(TIMEOUT),
                    .CNT_W(CNT_W)) u_phase_step_seq (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_dir(req_dir),
      .busy(busy), .step_done(step_done), .step_err(step_err),
      .pll_step(pll_step), .pll_updn(pll_updn), .pll_done(pll_done),
      .net_steps(net_steps)
   );

   // Synthesizer port model: one acknowledge pulse model_lat cycles into the strobe
   always @(posedge clk) begin
      if (pll_step) begin
         model_cnt <= model_cnt + 1;
         pll_done  <= (model_lat != 0) && (model_cnt + 1 == model_lat);
      end else begin
         model_cnt <= 0;
         pll_done  <= 1'b0;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_step(input logic dir, input int lat, input int wexp, input logic eexp);
      int width = 1;
      int pulses = 1;
      int bad_dir = 0;
      int guard = 0;
      int park_bad = 0;
      logic prev = 1'b1;
      model_lat = lat;
      @(negedge clk);
      req_dir = dir;
      req_start = 1'b1;
      @(negedge clk); chk("R2 strobe low after edge 1", int'(pll_step), 0);
      @(negedge clk); chk("R2 strobe low after edge 2", int'(pll_step), 0);
      @(negedge clk); chk("R2 busy high after edge 3", int'(busy), 1);
      if (pll_updn != dir) bad_dir++;
      req_dir = ~dir;
      while (!step_done && guard < 80) begin
         @(negedge clk);
         guard++;
         if (pll_step) begin
            width++;
            if (pll_updn != dir) bad_dir++;
         end
         if (pll_step && !prev) pulses++;
         prev = pll_step;
      end
      if (!eexp) exp_net = exp_net + (dir ? CNT_W'(1) : -CNT_W'(1));
      chk(eexp ? "R6 strobe width at timeout" : "R4 strobe width", width, wexp);
      chk("R6 error flag", int'(step_err), int'(eexp));
      chk("R3 direction held during strobe", bad_dir, 0);
      chk("R7 net count", int'(net_steps), int'(exp_net));
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (pll_step && !prev) pulses++;
         prev = pll_step;
         if (!step_done || busy) park_bad++;
      end
      chk("R1 single strobe per request", pulses, 1);
      chk("R5 parked while request held", park_bad, 0);
      chk("R5 late acknowledge ignored", int'(net_steps), int'(exp_net));
      req_start = 1'b0;
      @(negedge clk);
      @(negedge clk); chk("R5 still parked after edge 2", int'(step_done), 1);
      @(negedge clk); chk("R5 idle after edge 3", int'(step_done), 0);
   endtask

   initial begin : watchdog
      #(8 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 busy after reset", int'(busy), 0);
      chk("R8 step_done after reset", int'(step_done), 0);
      chk("R8 step_err after reset", int'(step_err), 0);
      chk("R8 strobe after reset", int'(pll_step), 0);
      chk("R8 net after reset", int'(net_steps), 0);

      for (int v = 0; v < NVEC; v++) begin
         run_step(VEC[v][11], int'(VEC[v][10:6]), int'(VEC[v][5:1]), VEC[v][0]);
      end

      // Forward run through the wrap point (R7)
      for (int k = 0; k < 5; k++) run_step(1'b1, 2, 4, 1'b0);
      chk("R7 count wrapped to -3", int'(net_steps), -3);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule